// File: doc/BRIEF.md
# Page Write Buffer with Commit Timer

This block sits behind a serial-bus slave's protocol engine and turns one write transaction into one atomic update of a 2048-byte storage array. The engine opens a transaction with a byte address. It gives a strobe at the moment the write-protect level must be captured, delivers each data byte with a strobe, and closes the transaction with a stop strobe. Incoming bytes land in a 16-entry page buffer. The offset inside the page advances after each byte and wraps inside the page, so the page number never changes during one transaction.

A stop that follows at least one accepted byte starts a commit. During the commit only the buffer entries that actually received data are copied into the array, and a busy flag is held for a programmable number of clock cycles. A protect level captured high rejects the whole transaction. The block answers every data byte with an acknowledge decision one cycle later, which the engine uses to drive the ninth clock bit. A combinational read port exposes the array contents.

Top module: `page_write_commit`

## Requirements
- R1: After reset, busy and ackValid are low and every array location reads 0xFF.
- R2: A data byte strobed inside an open, unprotected transaction while busy is low gets ackGood high, and the array stays unchanged until the commit that follows stop.
- R3: The start address splits into a page number (bits 10:4) and an offset (bits 3:0). Each accepted byte increments only the offset, modulo 16, so a 17th byte lands on the starting offset again and no neighbouring page is touched.
- R4: When more than one byte of a transaction lands on the same offset, the array holds the last of them after the commit.
- R5: A commit writes only the offsets that received a byte in that transaction, and all other locations of the page keep their previous contents.
- R6: A stop with no accepted byte in the transaction starts no commit: busy stays low and the array is unchanged.
- R7: The protect level is captured by wpStrobe only before the first accepted byte of a transaction. If the captured level is high, every data byte of that transaction gets ackGood low and stop commits nothing. If it is low, later changes of the protect level have no effect.
- R8: A commit raises busy in the cycle after the stop strobe, and busy stays high for exactly WR_CYCLES clock cycles.
- R9: While busy is high, txStart, data bytes and txStop are ignored and data bytes get ackGood low. A data byte outside any open transaction also gets ackGood low.
- R10: Every byteStrobe is answered by exactly one ackValid pulse in the following cycle. ackGood is high only together with ackValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txStart | input | 1 | Opens a write transaction at txAddr |
| txAddr | input | ADDR_W | Start byte address: page number in the upper bits, offset in the lower OFF_W bits |
| wpLevel | input | 1 | Write-protect level, high means protected |
| wpStrobe | input | 1 | Capture point for wpLevel, just before the first data byte |
| byteStrobe | input | 1 | A data byte is present on byteData |
| byteData | input | DATA_W | Data byte |
| txStop | input | 1 | Closes the transaction |
| ackValid | output | 1 | Acknowledge decision is present, one cycle after byteStrobe |
| ackGood | output | 1 | High to acknowledge the byte, low for NoACK |
| busy | output | 1 | Commit in progress |
| rdAddr | input | ADDR_W | Read address into the array |
| rdData | output | DATA_W | Array contents at rdAddr |

## Verification
A bench-side model holds a staging page and an expected array, and a scoreboard compares every acknowledge decision as it appears. Single-byte writes at a mid-page offset show that the bytes around the written one stay unchanged. An 18-byte burst that starts two entries before the end of a page separates wraparound from carrying into the next page, and it also tests which byte wins on a repeated offset. A short rewrite of a page that already holds data shows that the valid mask is honoured. Protect high at the capture point, protect toggled after the capture point, a stop with no bytes, and traffic during busy each test a separate reason for NoACK or for no commit. The length of the busy window is counted cycle by cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Strobes from the control path to the datapath, one cycle each.
  typedef struct packed {
    logic clrBuf;    // empty the page buffer's valid mask
    logic loadByte;  // store byteData at the current offset
    logic drainWe;   // copy one buffer entry to the array (if valid)
  } pwc_strobe_t;

endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic              wpLevel,
  input  logic              wpStrobe,
  input  logic              byteStrobe,
  input  logic              txStop,
  output logic              ackValid,
  output logic              ackGood,
  output logic              busy,
  output pwc_strobe_t       strobes,
  output logic [OFF_W-1:0]  bufIdx,
  output logic [OFF_W-1:0]  drainIdx,
  output logic [ADDR_W-OFF_W-1:0] pageNum
);

  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int TMR_W      = $clog2(WR_CYCLES + 1);
  localparam int DRN_W      = OFF_W + 1;

  logic              openTx;
  logic              gotByte;
  logic              wpHeld;
  logic [OFF_W-1:0]  offset;
  logic [PAGE_W-1:0] page;
  logic [TMR_W-1:0]  timer;
  logic [DRN_W-1:0]  drainCnt;

  logic startOk;
  logic acceptByte;
  logic commitNow;

  assign busy       = (timer != '0);
  assign startOk    = txStart && !busy;
  assign acceptByte = byteStrobe && openTx && !busy && !wpHeld;
  assign commitNow  = txStop && openTx && !busy && gotByte && !wpHeld;

  // Transaction state: page, running offset, protect capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openTx  <= 1'b0;
      gotByte <= 1'b0;
      wpHeld  <= 1'b0;
      offset  <= '0;
      page    <= '0;
    end else if (startOk) begin
      openTx  <= 1'b1;
      gotByte <= 1'b0;
      wpHeld  <= 1'b0;
      offset  <= txAddr[OFF_W-1:0];
      page    <= txAddr[ADDR_W-1:OFF_W];
    end else begin
      if (wpStrobe && openTx && !gotByte && !busy) begin
        wpHeld <= wpLevel;
      end
      if (acceptByte) begin
        offset  <= offset + 1'b1;
        gotByte <= 1'b1;
      end
      if (txStop && !busy) begin
        openTx <= 1'b0;
      end
    end
  end

  // Acknowledge decision, one cycle after each byte strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackGood  <= 1'b0;
    end else begin
      ackValid <= byteStrobe;
      ackGood  <= acceptByte;
    end
  end

  // Commit timer and page drain counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer    <= '0;
      drainCnt <= DRN_W'(PAGE_BYTES);
    end else if (commitNow) begin
      timer    <= TMR_W'(WR_CYCLES);
      drainCnt <= '0;
    end else begin
      if (timer != '0) begin
        timer <= timer - 1'b1;
      end
      if (strobes.drainWe) begin
        drainCnt <= drainCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clrBuf   = startOk;
    strobes.loadByte = acceptByte;
    strobes.drainWe  = busy && !drainCnt[OFF_W];
  end

  assign bufIdx   = offset;
  assign drainIdx = drainCnt[OFF_W-1:0];
  assign pageNum  = page;

endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwc_strobe_t       strobes,
  input  logic [OFF_W-1:0]  bufIdx,
  input  logic [OFF_W-1:0]  drainIdx,
  input  logic [ADDR_W-OFF_W-1:0] pageNum,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     cells   [DEPTH];

  // Staging page: data plus one valid bit per offset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) begin
        pageBuf[i] <= '0;
      end
    end else if (strobes.clrBuf) begin
      validMask <= '0;
    end else if (strobes.loadByte) begin
      pageBuf[bufIdx]   <= byteData;
      validMask[bufIdx] <= 1'b1;
    end
  end

  // Storage array, erased to all ones; one entry drained per cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '1;
      end
    end else if (strobes.drainWe && validMask[drainIdx]) begin
      cells[{pageNum, drainIdx}] <= pageBuf[drainIdx];
    end
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int OFF_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic              wpLevel,
  input  logic              wpStrobe,
  input  logic              byteStrobe,
  input  logic [DATA_W-1:0] byteData,
  input  logic              txStop,
  output logic              ackValid,
  output logic              ackGood,
  output logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  pwc_strobe_t       strobes;
  logic [OFF_W-1:0]  bufIdx;
  logic [OFF_W-1:0]  drainIdx;
  logic [PAGE_W-1:0] pageNum;

  pwc_ctrl #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .WR_CYCLES (WR_CYCLES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .txStart    (txStart),
    .txAddr     (txAddr),
    .wpLevel    (wpLevel),
    .wpStrobe   (wpStrobe),
    .byteStrobe (byteStrobe),
    .txStop     (txStop),
    .ackValid   (ackValid),
    .ackGood    (ackGood),
    .busy       (busy),
    .strobes    (strobes),
    .bufIdx     (bufIdx),
    .drainIdx   (drainIdx),
    .pageNum    (pageNum)
  );

  pwc_datapath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bufIdx   (bufIdx),
    .drainIdx (drainIdx),
    .pageNum  (pageNum),
    .byteData (byteData),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int WR_CYCLES = 500000
) (
  input logic clk,
  input logic rstN,
  input logic txStop,
  input logic byteStrobe,
  input logic ackValid,
  input logic ackGood,
  input logic busy
);

  int unsigned busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R8: busy only rises right after a stop strobe.
  a_r8_busy_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txStop));

  // R8: window never longer than WR_CYCLES.
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < WR_CYCLES));

  // R8: window ends exactly after WR_CYCLES cycles.
  a_r8_busy_exact: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == WR_CYCLES));

  // R9: no acknowledge for bytes arriving while busy.
  a_r9_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteStrobe) |=> !ackGood);

  // R10: one decision per byte strobe, in the next cycle.
  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rstN)
    byteStrobe |=> ackValid);

  a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rstN)
    !byteStrobe |=> !ackValid);

  a_r10_good_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    ackGood |-> ackValid);

endmodule

bind page_write_commit pwc_checker #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .txStop     (txStop),
  .byteStrobe (byteStrobe),
  .ackValid   (ackValid),
  .ackGood    (ackGood),
  .busy       (busy)
);

// File: tb/page_write_commit_tb_top.sv
`timescale 1ns/1ps
module page_write_commit_tb_top;

  localparam int W      = 40;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              txStart = 1'b0;
  logic [ADDR_W-1:0] txAddr = '0;
  logic              wpLevel = 1'b0;
  logic              wpStrobe = 1'b0;
  logic              byteStrobe = 1'b0;
  logic [7:0]        byteData = '0;
  logic              txStop = 1'b0;
  logic              ackValid, ackGood, busy;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;

  always #5 clk = ~clk;

  page_write_commit #(.WR_CYCLES(W)) dut_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txAddr(txAddr),
    .wpLevel(wpLevel), .wpStrobe(wpStrobe), .byteStrobe(byteStrobe),
    .byteData(byteData), .txStop(txStop), .ackValid(ackValid),
    .ackGood(ackGood), .busy(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nTests = 0;
  int nFail  = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model state derived from the requirements.
  logic [7:0]  expMem [DEPTH];
  logic [7:0]  mBuf [16];
  logic [15:0] mMask;
  logic [6:0]  mPage;
  logic [3:0]  mOff;
  bit mOpen = 0, mProt = 0, mGot = 0, mBusy = 0;
  bit expQ [$];

  // Scoreboard monitor: pops one expected decision per ackValid.
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected ackValid", 1, 0);
      end else begin
        bit e;
        e = expQ.pop_front();
        check("R2/R7/R9 ackGood", {31'd0, ackGood}, {31'd0, e});
      end
    end
  end

  task automatic startTx(logic [10:0] a);
    @(negedge clk); txStart = 1; txAddr = a;
    @(negedge clk); txStart = 0;
    if (!mBusy) begin
      mOpen = 1; mPage = a[10:4]; mOff = a[3:0];
      mMask = '0; mProt = 0; mGot = 0;
    end
  endtask

  task automatic sampleWp(bit lvl);
    @(negedge clk); wpLevel = lvl; wpStrobe = 1;
    @(negedge clk); wpStrobe = 0;
    if (mOpen && !mGot && !mBusy) mProt = lvl;
  endtask

  task automatic sendByte(logic [7:0] d);
    bit ok;
    ok = mOpen && !mBusy && !mProt;
    expQ.push_back(ok);
    if (ok) begin
      mBuf[mOff] = d; mMask[mOff] = 1'b1; mOff = mOff + 1'b1; mGot = 1;
    end
    @(negedge clk); byteStrobe = 1; byteData = d;
    @(negedge clk); byteStrobe = 0;
  endtask

  task automatic stopTx();
    @(negedge clk); txStop = 1;
    @(negedge clk); txStop = 0;
    if (mOpen && !mBusy) begin
      mOpen = 0;
      if (mGot && !mProt) begin
        for (int i = 0; i < 16; i++)
          if (mMask[i]) expMem[{mPage, 4'(i)}] = mBuf[i];
        mBusy = 1;
      end
    end
  endtask

  task automatic measureBusy(string req);
    int n = 0;
    while (busy && n < W + 10) begin
      n++;
      @(negedge clk);
    end
    check(req, n, W);
    mBusy = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    mBusy = 0;
  endtask

  task automatic staysIdle(string req);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req, {31'd0, busy}, 0);
    end
  endtask

  task automatic readChk(string req, logic [10:0] a);
    rdAddr = a; #1;
    check(req, {24'd0, rdData}, {24'd0, expMem[a]});
  endtask

  task automatic pageChk(string req, logic [6:0] p);
    for (int i = 0; i < 16; i++) readChk(req, {p, 4'(i)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 ackValid", {31'd0, ackValid}, 0);
    readChk("R1 erased", 11'h000);
    readChk("R1 erased", 11'h7FF);
    readChk("R1 erased", 11'h123);

    // R9: byte with no transaction open
    sendByte(8'h5A);

    // R2, R5, R8: single byte mid-page
    startTx(11'h035);
    sampleWp(0);
    sendByte(8'hA5);
    rdAddr = 11'h035; #1;
    check("R2 no write before stop", {24'd0, rdData}, 32'hFF);
    stopTx();
    measureBusy("R8 busy length");
    pageChk("R5 single byte", 7'h03);

    // R3, R4: 18 bytes from offset 14, wrap within page
    startTx(11'h1FE);
    sampleWp(0);
    for (int i = 0; i < 18; i++) sendByte(8'h10 + 8'(i));
    stopTx();
    measureBusy("R8 busy length burst");
    pageChk("R3 R4 wrapped page", 7'h1F);
    readChk("R3 next page untouched", 11'h200);
    readChk("R3 prev page untouched", 11'h1EF);

    // R5: partial rewrite keeps other offsets
    startTx(11'h030);
    sampleWp(0);
    sendByte(8'hC0);
    sendByte(8'hC1);
    stopTx();
    measureBusy("R8 busy length partial");
    pageChk("R5 masked commit", 7'h03);

    // R6: stop with no data
    startTx(11'h050);
    sampleWp(0);
    stopTx();
    staysIdle("R6 no commit");
    readChk("R6 array unchanged", 11'h050);

    // R7: protected transaction rejected
    startTx(11'h060);
    sampleWp(1);
    wpLevel = 0;
    sendByte(8'h11);
    sendByte(8'h22);
    stopTx();
    staysIdle("R7 protected no commit");
    pageChk("R7 protected page", 7'h06);

    // R7: protect rising after capture has no effect
    startTx(11'h070);
    sampleWp(0);
    wpLevel = 1;
    sendByte(8'h33);
    sampleWp(1);
    sendByte(8'h34);
    stopTx();
    wpLevel = 0;
    measureBusy("R7 late protect ignored");
    pageChk("R7 late protect", 7'h07);

    // R9: traffic during busy ignored
    startTx(11'h0A0);
    sampleWp(0);
    sendByte(8'h77);
    stopTx();
    startTx(11'h080);
    sendByte(8'h44);
    stopTx();
    waitIdle();
    staysIdle("R9 no commit from busy traffic");
    readChk("R9 busy write dropped", 11'h080);
    readChk("R9 earlier commit done", 11'h0A0);
    sendByte(8'h45);

    @(negedge clk);
    @(negedge clk);
    check("R10 all decisions seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule